// File: doc/BRIEF.md
# Prioritized Processor Interrupt Selector

This block holds one pending flag for each of seven interrupt classes and picks which of them a processor core should service next. Other logic raises a class by posting its number. When the core strobes `take`, the block reads the current processor state and applies fixed priority rules to choose one class. The state it reads is the privilege mode, the interrupt enable, the enable for the trap-level-zero trap, the trap level, bit 0 of the hypervisor interrupt-pending word, the soft-interrupt register and the processor interrupt level. On the next cycle it reports a one-cycle result: either a trap code, with a level when the trap is a soft interrupt, or no trap.

Priority depends on the mode. Some classes are consumed without any trap being delivered. The highest soft-interrupt level is compared with the processor interrupt level, and the interrupt-vector class sits at level 6 within that ordering. A pending counter drives the any-pending output.

Top module: `irq_arbiter`

## Requirements
- R1: A post of class 0..6 sets that class's pending flag and increments the pending count. `any_pend` is high exactly when the count is nonzero. A synchronous active-high reset clears all flags and the count. Class numbers are: 0 trap-level-zero, 1 hstick-match, 2 interrupt-vector, 3 cpu-mondo, 4 dev-mondo, 5 resumable-error, 6 soft-interrupt.
- R2: A post of class 7 sets no flag, leaves the count alone, and pulses `post_err` high for one cycle on the clock edge after the post.
- R3: Each `take` yields `res_vld` high for exactly one cycle, on the edge after the strobe. `res_trap` carries the chosen code: 0 none, 1 trap-level-zero, 2 hstick-match, 3 cpu-mondo, 4 dev-mondo, 5 soft level, 6 resumable-error. Servicing a class clears its flag and decrements the count on that same edge.
- R4: When `hpriv`=1 and `ie`=1, hstick-match is delivered first, but only while `hintp0`=1. Failing that, a pending interrupt-vector is cleared with result code 0.
- R5: When `hpriv`=1 and `ie`=0, the result is code 0 and every flag stays as it was.
- R6: When `hpriv`=0, trap-level-zero is checked first and is delivered only if `tlz_en`=1 and `tl`=0. Hstick-match is checked next and is gated by `hintp0`. Neither check depends on `ie`.
- R7: When `hpriv`=0 and `ie`=1, the classes after those two are tried in this order: cpu-mondo, dev-mondo, soft-interrupt, resumable-error.
- R8: The soft-interrupt level is the highest set bit among bits 1..15 of `softint`, or 0 if none of those bits is set. Bits 0 and 16 are ignored. If the level is below 6 and interrupt-vector is pending, interrupt-vector is consumed with code 0. Otherwise a level trap is delivered (code 5, `res_lvl` = level) only if the level is greater than `pil`. If neither applies, selection falls through to resumable-error.
- R9: After a level trap, the soft-interrupt flag is cleared only when no other bit among 1..15 of `softint` is set.
- R10: Posting a class that is already pending increments the count again. A single service decrements it once, so `any_pend` stays high.
- R11: A post and a take in the same cycle resolve with the post applied after the take, so a class that is serviced and re-posted in that cycle stays pending.
- R12: `res_lvl` is 0 for every result whose code is not 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Post request strobe |
| post_cls | input | 3 | Class number to post |
| take | input | 1 | Request the next interrupt selection |
| hpriv | input | 1 | Hypervisor-privileged mode |
| ie | input | 1 | Interrupt enable |
| tlz_en | input | 1 | Trap-level-zero trap enable |
| tl | input | 3 | Current trap level |
| hintp0 | input | 1 | Bit 0 of the hypervisor interrupt-pending word |
| softint | input | 17 | Soft-interrupt register |
| pil | input | 4 | Processor interrupt level |
| any_pend | output | 1 | Pending count is nonzero |
| post_err | output | 1 | One-cycle pulse after an invalid post |
| res_vld | output | 1 | Selection result valid |
| res_trap | output | 3 | Chosen trap code |
| res_lvl | output | 4 | Level of a soft-interrupt trap |

## Verification
The bench sweeps every single class against every combination of mode, enable, trap-level-zero enable, trap level and hstick gate. Any wrong mode gate shows up there either as a trap delivered where none is allowed or as a flag consumed that should have stayed. It then sweeps every soft level 1..15 against every processor interrupt level, with and without interrupt-vector pending. That sweep catches an off-by-one at level 6 or at the `pil` comparison, which would give the wrong code or wrongly clear interrupt-vector. Directed runs cover the remaining corners. Several soft levels set at once must leave the soft flag pending. A repeated post must keep `any_pend` high. A post in the same cycle as a take must survive the take; a design that applies the take last would lose it.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NUM_CLS = 7;

    typedef enum logic [2:0] {
        CLS_TLZ  = 3'd0,
        CLS_HSM  = 3'd1,
        CLS_IVEC = 3'd2,
        CLS_CPUQ = 3'd3,
        CLS_DEVQ = 3'd4,
        CLS_RERR = 3'd5,
        CLS_SOFT = 3'd6
    } irq_cls_e;

    typedef enum logic [2:0] {
        TRAP_NONE   = 3'd0,
        TRAP_TLZ    = 3'd1,
        TRAP_HSTICK = 3'd2,
        TRAP_CPUQ   = 3'd3,
        TRAP_DEVQ   = 3'd4,
        TRAP_LEVEL  = 3'd5,
        TRAP_RERR   = 3'd6
    } trap_e;

endpackage

// File: rtl/irq_lvl_enc.sv
// Highest-set-level search over the soft-interrupt register (R8, R9).
module irq_lvl_enc #(
    parameter int SOFT_W = 17,
    parameter int LVL_W  = 4
) (
    input  logic [SOFT_W-1:0] vec,
    output logic [LVL_W-1:0]  top_lvl,
    output logic              others_set
);
    localparam int MAX_LVL = (1 << LVL_W) - 1;
    localparam int TOP     = (SOFT_W - 1 < MAX_LVL) ? SOFT_W - 1 : MAX_LVL;

    logic [SOFT_W-1:0] lvl_bits;
    logic [SOFT_W-1:0] rest_bits;

    always_comb begin
        lvl_bits = '0;
        top_lvl  = '0;
        for (int i = 0; i < SOFT_W; i++) begin
            if (vec[i] && i >= 1 && i <= TOP) begin
                lvl_bits[i] = 1'b1;
                top_lvl     = LVL_W'(i);
            end
        end
        rest_bits = lvl_bits;
        rest_bits[top_lvl] = 1'b0;
        others_set = |rest_bits;
    end
endmodule

// File: rtl/irq_pick.sv
// Mode-dependent priority selection (R4..R9).
module irq_pick
    import irq_pkg::*;
#(
    parameter int LVL_W    = 4,
    parameter int IVEC_LVL = 6
) (
    input  logic [NUM_CLS-1:0] pend,
    input  logic               hpriv,
    input  logic               ie,
    input  logic               tlz_en,
    input  logic               tl_zero,
    input  logic               hintp0,
    input  logic [LVL_W-1:0]   soft_lvl,
    input  logic               soft_others,
    input  logic [LVL_W-1:0]   pil,
    output logic [NUM_CLS-1:0] clr,
    output trap_e              trap,
    output logic [LVL_W-1:0]   lvl
);
    localparam logic [LVL_W-1:0] IVEC_AT = LVL_W'(IVEC_LVL);

    logic soft_hit;

    always_comb begin
        clr      = '0;
        trap     = TRAP_NONE;
        lvl      = '0;
        soft_hit = 1'b0;
        if (hpriv) begin
            if (ie) begin
                if (pend[CLS_HSM] && hintp0) begin
                    clr[CLS_HSM] = 1'b1;
                    trap         = TRAP_HSTICK;
                end else if (pend[CLS_IVEC]) begin
                    clr[CLS_IVEC] = 1'b1;
                end
            end
        end else begin
            if (pend[CLS_TLZ] && tlz_en && tl_zero) begin
                clr[CLS_TLZ] = 1'b1;
                trap         = TRAP_TLZ;
            end else if (pend[CLS_HSM] && hintp0) begin
                clr[CLS_HSM] = 1'b1;
                trap         = TRAP_HSTICK;
            end else if (ie) begin
                if (pend[CLS_CPUQ]) begin
                    clr[CLS_CPUQ] = 1'b1;
                    trap          = TRAP_CPUQ;
                end else if (pend[CLS_DEVQ]) begin
                    clr[CLS_DEVQ] = 1'b1;
                    trap          = TRAP_DEVQ;
                end else begin
                    if (pend[CLS_SOFT]) begin
                        if (soft_lvl < IVEC_AT && pend[CLS_IVEC]) begin
                            clr[CLS_IVEC] = 1'b1;
                            soft_hit      = 1'b1;
                        end else if (soft_lvl > pil) begin
                            clr[CLS_SOFT] = !soft_others;
                            trap          = TRAP_LEVEL;
                            lvl           = soft_lvl;
                            soft_hit      = 1'b1;
                        end
                    end
                    if (!soft_hit && pend[CLS_RERR]) begin
                        clr[CLS_RERR] = 1'b1;
                        trap          = TRAP_RERR;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int SOFT_W   = 17,
    parameter int LVL_W    = 4,
    parameter int TL_W     = 3,
    parameter int CNT_W    = 8,
    parameter int IVEC_LVL = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              post_vld,
    input  logic [2:0]        post_cls,
    input  logic              take,
    input  logic              hpriv,
    input  logic              ie,
    input  logic              tlz_en,
    input  logic [TL_W-1:0]   tl,
    input  logic              hintp0,
    input  logic [SOFT_W-1:0] softint,
    input  logic [LVL_W-1:0]  pil,
    output logic              any_pend,
    output logic              post_err,
    output logic              res_vld,
    output logic [2:0]        res_trap,
    output logic [LVL_W-1:0]  res_lvl
);
    localparam logic [2:0]       CLS_LIMIT = 3'(NUM_CLS);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;

    typedef struct packed {
        logic [NUM_CLS-1:0] pend;
        logic [CNT_W-1:0]   cnt;
        logic               rvld;
        trap_e              rtrap;
        logic [LVL_W-1:0]   rlvl;
        logic               perr;
    } state_t;

    state_t s_d, s_q;

    logic [LVL_W-1:0]   soft_lvl;
    logic               soft_others;
    logic [NUM_CLS-1:0] pick_clr;
    trap_e              pick_trap;
    logic [LVL_W-1:0]   pick_lvl;
    logic               cls_ok;
    logic               inc_d, dec_d;

    irq_lvl_enc #(.SOFT_W(SOFT_W), .LVL_W(LVL_W)) u_enc (
        .vec        (softint),
        .top_lvl    (soft_lvl),
        .others_set (soft_others)
    );

    irq_pick #(.LVL_W(LVL_W), .IVEC_LVL(IVEC_LVL)) u_pick (
        .pend        (s_q.pend),
        .hpriv       (hpriv),
        .ie          (ie),
        .tlz_en      (tlz_en),
        .tl_zero     (tl == '0),
        .hintp0      (hintp0),
        .soft_lvl    (soft_lvl),
        .soft_others (soft_others),
        .pil         (pil),
        .clr         (pick_clr),
        .trap        (pick_trap),
        .lvl         (pick_lvl)
    );

    always_comb begin
        s_d    = s_q;
        cls_ok = post_cls < CLS_LIMIT;
        inc_d  = post_vld && cls_ok;
        dec_d  = take && (|pick_clr);

        s_d.rvld  = take;
        s_d.perr  = post_vld && !cls_ok;
        s_d.rtrap = take ? pick_trap : TRAP_NONE;
        s_d.rlvl  = take ? pick_lvl : '0;

        // take first, then the post (R11)
        if (take) begin
            s_d.pend = s_q.pend & ~pick_clr;
        end
        if (inc_d) begin
            s_d.pend[post_cls] = 1'b1;
        end

        unique case ({inc_d, dec_d})
            2'b10:   if (s_q.cnt != CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   if (s_q.cnt != '0)      s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign any_pend = s_q.cnt != '0;
    assign post_err = s_q.perr;
    assign res_vld  = s_q.rvld;
    assign res_trap = s_q.rtrap;
    assign res_lvl  = s_q.rlvl;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             post_vld,
    input logic [2:0]       post_cls,
    input logic             take,
    input logic             hpriv,
    input logic             ie,
    input logic [LVL_W-1:0] pil,
    input logic             any_pend,
    input logic             post_err,
    input logic             res_vld,
    input logic [2:0]       res_trap,
    input logic [LVL_W-1:0] res_lvl
);
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> !any_pend);

    p_bad_post_flags_r2: assert property (@(posedge clk) disable iff (rst)
        (post_vld && post_cls == 3'd7) |=> post_err);

    p_take_yields_result_r3: assert property (@(posedge clk) disable iff (rst)
        take |=> res_vld);

    p_no_spurious_result_r3: assert property (@(posedge clk) disable iff (rst)
        !take |=> !res_vld);

    p_hpriv_masked_r5: assert property (@(posedge clk) disable iff (rst)
        (take && hpriv && !ie) |=> (res_trap == 3'd0));

    p_level_above_pil_r8: assert property (@(posedge clk) disable iff (rst)
        (res_vld && res_trap == 3'd5) |-> (res_lvl > $past(pil)));

    p_level_zero_otherwise_r12: assert property (@(posedge clk) disable iff (rst)
        (res_trap != 3'd5) |-> (res_lvl == '0));
endmodule

bind irq_arbiter irq_arbiter_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
    logic        clk = 1'b0;
    logic        rst, post_vld, take, hpriv, ie, tlz_en, hintp0;
    logic [2:0]  post_cls, tl;
    logic [16:0] softint;
    logic [3:0]  pil;
    logic        any_pend, post_err, res_vld;
    logic [2:0]  res_trap;
    logic [3:0]  res_lvl;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    irq_arbiter uut (
        .clk(clk), .rst(rst), .post_vld(post_vld), .post_cls(post_cls),
        .take(take), .hpriv(hpriv), .ie(ie), .tlz_en(tlz_en), .tl(tl),
        .hintp0(hintp0), .softint(softint), .pil(pil), .any_pend(any_pend),
        .post_err(post_err), .res_vld(res_vld), .res_trap(res_trap),
        .res_lvl(res_lvl)
    );

    always #5 clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: act=%0d exp=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; post_vld = 0; post_cls = 0; take = 0; hpriv = 0; ie = 0;
        tlz_en = 0; tl = 0; hintp0 = 0; softint = 0; pil = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic do_post(input int c);
        @(negedge clk);
        post_vld = 1; post_cls = 3'(c);
        @(negedge clk);
        post_vld = 0;
    endtask

    task automatic do_take();
        @(negedge clk);
        take = 1;
        @(negedge clk);
        take = 0;
    endtask

    task automatic chk_res(input string req, input int trap, input int lvl);
        chk(res_vld == 1'b1, req, int'(res_vld), 1);
        chk(int'(res_trap) == trap, req, int'(res_trap), trap);
        chk(int'(res_lvl) == lvl, req, int'(res_lvl), lvl);
    endtask

    // expected result for one pending class with softint = 0
    function automatic int exp_single(input int c, input bit hp, input bit en,
                                      input bit tze, input bit tlz0, input bit h0,
                                      output bit cons);
        cons = 0;
        exp_single = 0;
        case (c)
            0: if (!hp && tze && tlz0) begin cons = 1; exp_single = 1; end
            1: if (h0 && (!hp || en)) begin cons = 1; exp_single = 2; end
            2: if (hp && en) cons = 1;
            3: if (!hp && en) begin cons = 1; exp_single = 3; end
            4: if (!hp && en) begin cons = 1; exp_single = 4; end
            5: if (!hp && en) begin cons = 1; exp_single = 6; end
            default: ;
        endcase
    endfunction

    initial begin
        do_reset();
        // R1 reset state
        chk(any_pend == 0, "R1 reset any_pend", int'(any_pend), 0);
        chk(res_vld == 0, "R3 reset res_vld", int'(res_vld), 0);

        // R2 invalid class
        do_post(7);
        chk(post_err == 1, "R2 post_err", int'(post_err), 1);
        chk(any_pend == 0, "R2 no flag", int'(any_pend), 0);
        @(negedge clk);
        chk(post_err == 0, "R2 pulse ends", int'(post_err), 0);

        // R4 R5 R6 R7 single-class sweep
        for (int c = 0; c < 7; c++) begin
            for (int m = 0; m < 32; m++) begin
                bit cons;
                int et;
                do_reset();
                do_post(c);
                chk(any_pend == 1, "R1 post sets", int'(any_pend), 1);
                hpriv = m[0]; ie = m[1]; tlz_en = m[2];
                tl = m[3] ? 3'd0 : 3'd3; hintp0 = m[4];
                et = exp_single(c, m[0], m[1], m[2], m[3], m[4], cons);
                do_take();
                chk_res("R4_R5_R6_R7 sweep trap", et, 0);
                chk(any_pend == !cons, "R3 sweep consume", int'(any_pend), int'(!cons));
                @(negedge clk);
                chk(res_vld == 0, "R3 one-cycle", int'(res_vld), 0);
            end
        end

        // R8 R9 soft level sweep
        for (int lv = 1; lv < 16; lv++) begin
            for (int p = 0; p < 16; p++) begin
                for (int iv = 0; iv < 2; iv++) begin
                    int et, el;
                    bit ep;
                    do_reset();
                    do_post(6);
                    if (iv == 1) do_post(2);
                    ie = 1; softint = 17'(1 << lv); pil = 4'(p);
                    do_take();
                    if (lv < 6 && iv == 1) begin et = 0; el = 0; ep = 1; end
                    else if (lv > p) begin et = 5; el = lv; ep = (iv == 1); end
                    else begin et = 0; el = 0; ep = 1; end
                    chk_res("R8 soft level", et, el);
                    chk(any_pend == ep, "R9 soft flag", int'(any_pend), int'(ep));
                end
            end
        end

        // R9 several levels keep the soft flag
        do_reset();
        do_post(6);
        ie = 1; softint = 17'((1 << 9) | (1 << 3)); pil = 0;
        do_take();
        chk_res("R9 top level", 5, 9);
        chk(any_pend == 1, "R9 flag kept", int'(any_pend), 1);
        softint = 17'(1 << 3);
        do_take();
        chk_res("R9 next level", 5, 3);
        chk(any_pend == 0, "R9 flag cleared", int'(any_pend), 0);

        // R8 bits 0 and 16 ignored
        do_reset();
        do_post(6);
        ie = 1; softint = 17'h10001; pil = 0;
        do_take();
        chk_res("R8 ignored bits", 0, 0);
        chk(any_pend == 1, "R8 soft stays", int'(any_pend), 1);

        // R6 R7 full order
        do_reset();
        for (int c = 0; c < 7; c++) do_post(c);
        ie = 1; tlz_en = 1; tl = 0; hintp0 = 1; softint = 17'(1 << 9); pil = 2;
        do_take(); chk_res("R6 tlz first", 1, 0);
        do_take(); chk_res("R6 hstick second", 2, 0);
        do_take(); chk_res("R7 cpu", 3, 0);
        do_take(); chk_res("R7 dev", 4, 0);
        do_take(); chk_res("R7 soft", 5, 9);
        softint = 0;
        do_take(); chk_res("R7 rerr", 6, 0);
        do_take(); chk_res("R7 nothing left", 0, 0);
        chk(any_pend == 1, "R7 ivec remains", int'(any_pend), 1);
        hpriv = 1;
        do_take(); chk_res("R4 ivec consumed", 0, 0);
        chk(any_pend == 0, "R4 empty", int'(any_pend), 0);

        // R4 hstick before ivec
        do_reset();
        do_post(2); do_post(1);
        hpriv = 1; ie = 1; hintp0 = 1;
        do_take(); chk_res("R4 hstick first", 2, 0);
        chk(any_pend == 1, "R4 ivec left", int'(any_pend), 1);

        // R5 flags unchanged, then deliverable
        do_reset();
        do_post(3);
        hpriv = 1; ie = 0;
        do_take(); chk_res("R5 masked", 0, 0);
        hpriv = 0; ie = 1;
        do_take(); chk_res("R5 flag kept", 3, 0);

        // R10 double post
        do_reset();
        do_post(5); do_post(5);
        ie = 1;
        do_take(); chk_res("R10 rerr", 6, 0);
        chk(any_pend == 1, "R10 count stays", int'(any_pend), 1);
        do_take(); chk_res("R10 flag gone", 0, 0);

        // R11 post with take
        do_reset();
        do_post(3);
        ie = 1;
        @(negedge clk);
        take = 1; post_vld = 1; post_cls = 3;
        @(negedge clk);
        take = 0; post_vld = 0;
        chk_res("R11 taken", 3, 0);
        chk(any_pend == 1, "R11 reposted", int'(any_pend), 1);
        do_take(); chk_res("R11 again", 3, 0);
        chk(any_pend == 0, "R11 empty", int'(any_pend), 0);

        finish_run();
    end
endmodule